// File: doc/BRIEF.md
# Dual-Mode Serial Port

This block is one serial channel that works in two ways. In asynchronous mode it is a full-duplex UART. A frame is a low start bit, then 8 or 9 data bits, then an optional parity bit, then one or two high stop bits. In synchronous mode it is a half-duplex byte shifter. It drives its own shift clock and moves exactly 8 bits in one direction per transfer. Both modes shift the least significant bit first.

A separate baud generator supplies a single-cycle `tick` at sixteen times the bit rate. Software loads a character with `tx_wr` and collects received characters from a one-deep buffer with `rx_rd`. Each received character carries its own parity and framing flags. An overrun flag records a character that was lost because the buffer was still full.

A multiprocessor wake-up mode sends 9-bit characters whose top bit marks an address. While that mode is on, the receiver drops every character whose top bit is clear. A loopback switch feeds the transmitter output straight into the receiver and holds the transmit pin idle. Three strobe outputs signal transmit completion, receive completion and errors.

Top module: `dualmode_serial`

## Requirements
- R1: In asynchronous mode, `txd` idles at 1. After `tx_wr` it sends a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then one stop bit at 1 (two when `cfg_two_stop` is set). Each bit lasts 16 ticks.
- R2: Each frame has 9 data bits when `cfg_nine` or `cfg_wake` is set, and 8 otherwise. `rx_data[8]` reads 0 for 8-bit frames.
- R3: When `cfg_par_en` is set, the parity bit makes the count of ones over the data bits and the parity bit even, or odd if `cfg_par_odd` is set. A received mismatch sets `err_par` together with the character.
- R4: A stop bit sampled as 0 sets `err_frame` together with the character.
- R5: A character that completes while `rx_valid` is 1 and `rx_rd` is low sets `err_over`. The buffered character and its flags stay unchanged.
- R6: While `cfg_wake` is set, a character whose ninth bit is 0 is discarded: no buffer load, no flag and no strobe. A character whose ninth bit is 1 is delivered with `rx_data[8]` = 1.
- R7: The receiver samples each bit at its middle, 8 ticks into it. A low pulse shorter than half a bit on an idle line is not taken as a start bit.
- R8: In synchronous mode, `tx_wr` shifts out `tx_data[7:0]` LSB first on `txd`. Each bit lasts 16 ticks. `sclk` is low for the first 8 ticks of each bit and high for the last 8, and `txd` is stable at every rising edge of `sclk`. `sclk` idles at 1.
- R9: In synchronous mode, `sync_rx_go` starts an 8-clock receive. The bit on `rxd` is sampled at each rising edge of `sclk`, LSB first, and the byte is loaded into the receive buffer.
- R10: With `cfg_loop` set, the receiver takes the transmitter's output instead of `rxd`, and `txd` stays at 1.
- R11: `irq_tx` pulses for one cycle when a transmission ends. `irq_rx` pulses when a character enters the buffer. `irq_err` pulses when a parity, framing or overrun error is recorded.
- R12: `tx_wr` or `sync_rx_go` while `tx_busy` is 1 is ignored. The frame in progress continues unchanged.
- R13: `rx_rd` clears `rx_valid`, `err_par`, `err_frame` and `err_over` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| cfg_sync | input | 1 | 1 selects synchronous mode |
| cfg_nine | input | 1 | 9 data bits in asynchronous mode |
| cfg_wake | input | 1 | Wake-up mode (9 bits, address filter) |
| cfg_two_stop | input | 1 | Two stop bits on transmit |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_loop | input | 1 | Internal loopback |
| tx_data | input | 9 | Character to send |
| tx_wr | input | 1 | Start a transmission |
| sync_rx_go | input | 1 | Start a synchronous receive |
| tx_busy | output | 1 | Shift engine active |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Receive buffer full |
| rx_rd | input | 1 | Take the buffered character |
| err_par | output | 1 | Parity error on buffered character |
| err_frame | output | 1 | Framing error on buffered character |
| err_over | output | 1 | Overrun since last read |
| irq_tx | output | 1 | Transmit done strobe |
| irq_rx | output | 1 | Receive done strobe |
| irq_err | output | 1 | Error strobe |
| txd | output | 1 | Serial data out |
| sclk | output | 1 | Synchronous shift clock |
| rxd | input | 1 | Serial data in |

## Verification
With a tick on every cycle, transmit bit k is on `txd` from 16k to 16k+16 cycles after the edge that accepts `tx_wr`. `tx_busy` falls and `irq_tx` pulses exactly 16·L edges after that accept, where L is the frame length. The bench counts falling clock edges from the accept edge and samples each bit at offset 16k+8, the middle of the bit. It checks the end strobe on the exact 16·L edge. A received character appears about half a stop bit plus two synchronizer cycles after the stop bit begins. The bench therefore waits two idle bit times after each driven frame before it reads the buffer. The strobes are counted on falling edges so that each one-cycle pulse is seen once. The bench drives synchronous receive data when it sees `sclk` go low, which leaves eight ticks before the sampling edge.

// File: rtl/dualmode_serial.sv
module dualmode_serial #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_sync,
  input  logic       cfg_nine,
  input  logic       cfg_wake,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_loop,
  input  logic [8:0] tx_data,
  input  logic       tx_wr,
  input  logic       sync_rx_go,
  output logic       tx_busy,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_rd,
  output logic       err_par,
  output logic       err_frame,
  output logic       err_over,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_err,
  output logic       txd,
  output logic       sclk,
  input  logic       rxd
);
  localparam int CW = $clog2(OVS);
  localparam int FW = 13;
  localparam logic [CW-1:0] C_MID = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] C_END = CW'(OVS - 1);
  localparam logic [CW-1:0] C_HALF = CW'(OVS/2);

  // shared shift engine: async transmit, sync transmit, sync receive
  logic [CW-1:0] tcnt;
  logic [3:0]    tleft;
  logic [FW-1:0] tsh;
  logic          tsync, trecv;
  logic [3:0]    nd, flen;
  logic [8:0]    tx_masked;
  logic [FW-1:0] frame;
  logic          tx_start, srx_start, srx_done, tline, rx_line;
  logic          rxd_m, rxd_s;

  assign nd        = (cfg_nine || cfg_wake) ? 4'd9 : 4'd8;
  assign flen      = 4'd1 + nd + {3'b000, cfg_par_en} + (cfg_two_stop ? 4'd2 : 4'd1);
  assign tx_masked = (nd == 4'd9) ? tx_data : {1'b0, tx_data[7:0]};
  assign tx_start  = tx_wr && !tx_busy;
  assign srx_start = cfg_sync && sync_rx_go && !tx_busy && !tx_wr;

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nd)) frame[1+i] = tx_data[i];
    if (cfg_par_en) frame[1+int'(nd)] = (^tx_masked) ^ cfg_par_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tcnt    <= '0;
      tleft   <= '0;
      tsh     <= '1;
      tsync   <= 1'b0;
      trecv   <= 1'b0;
      irq_tx  <= 1'b0;
    end else begin
      irq_tx <= 1'b0;
      if (tx_start) begin
        tx_busy <= 1'b1;
        tcnt    <= '0;
        tsync   <= cfg_sync;
        trecv   <= 1'b0;
        tsh     <= cfg_sync ? {5'h1f, tx_data[7:0]} : frame;
        tleft   <= cfg_sync ? 4'd8 : flen;
      end else if (srx_start) begin
        tx_busy <= 1'b1;
        tcnt    <= '0;
        tsync   <= 1'b1;
        trecv   <= 1'b1;
        tsh     <= '1;
        tleft   <= 4'd8;
      end else if (tx_busy && tick) begin
        tcnt <= (tcnt == C_END) ? '0 : tcnt + 1'b1;
        if (trecv && tcnt == C_MID) tsh[7:0] <= {rx_line, tsh[7:1]};
        if (tcnt == C_END) begin
          if (!trecv) tsh <= {1'b1, tsh[FW-1:1]};
          tleft <= tleft - 1'b1;
          if (tleft == 4'd1) begin
            tx_busy <= 1'b0;
            irq_tx  <= !trecv;
          end
        end
      end
    end
  end

  assign srx_done = tx_busy && trecv && tick && tcnt == C_END && tleft == 4'd1;
  assign tline    = (tx_busy && !trecv) ? tsh[0] : 1'b1;
  assign txd      = cfg_loop ? 1'b1 : tline;
  assign sclk     = !(tx_busy && tsync && tcnt < C_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  assign rx_line = cfg_loop ? tline : rxd_s;

  // asynchronous receiver
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_STOP} rx_state_t;
  rx_state_t     rstate;
  logic [CW-1:0] rcnt;
  logic [3:0]    ridx;
  logic [9:0]    rsh;
  logic          arx_done, arx_keep, arx_perr, arx_ferr;
  logic [8:0]    arx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstate <= R_IDLE;
      rcnt   <= '0;
      ridx   <= '0;
      rsh    <= '0;
    end else if (cfg_sync) begin
      rstate <= R_IDLE;
    end else begin
      case (rstate)
        R_IDLE: if (!rx_line) begin
          rstate <= R_START;
          rcnt   <= '0;
        end
        R_START: if (tick) begin
          if (rcnt == C_MID) begin
            rcnt   <= '0;
            ridx   <= '0;
            rstate <= rx_line ? R_IDLE : R_BITS;
          end else rcnt <= rcnt + 1'b1;
        end
        R_BITS: if (tick) begin
          if (rcnt == C_END) begin
            rcnt      <= '0;
            rsh[ridx] <= rx_line;
            ridx      <= ridx + 1'b1;
            if (ridx == nd + {3'b000, cfg_par_en} - 4'd1) rstate <= R_STOP;
          end else rcnt <= rcnt + 1'b1;
        end
        R_STOP: if (tick) begin
          if (rcnt == C_END) rstate <= R_IDLE;
          else rcnt <= rcnt + 1'b1;
        end
        default: rstate <= R_IDLE;
      endcase
    end
  end

  assign arx_done = !cfg_sync && rstate == R_STOP && tick && rcnt == C_END;
  assign arx_data = (nd == 4'd9) ? rsh[8:0] : {1'b0, rsh[7:0]};
  assign arx_perr = cfg_par_en && (rsh[nd] != ((^arx_data) ^ cfg_par_odd));
  assign arx_ferr = !rx_line;
  assign arx_keep = !(cfg_wake && !arx_data[8]);

  // receive buffer
  logic       dlv, dlv_perr, dlv_ferr;
  logic [8:0] dlv_data;

  assign dlv      = srx_done || (arx_done && arx_keep);
  assign dlv_data = srx_done ? {1'b0, tsh[7:0]} : arx_data;
  assign dlv_perr = !srx_done && arx_perr;
  assign dlv_ferr = !srx_done && arx_ferr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      err_par   <= 1'b0;
      err_frame <= 1'b0;
      err_over  <= 1'b0;
      irq_rx    <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
      if (rx_rd) begin
        rx_valid  <= 1'b0;
        err_par   <= 1'b0;
        err_frame <= 1'b0;
        err_over  <= 1'b0;
      end
      if (dlv) begin
        if (rx_valid && !rx_rd) begin
          err_over <= 1'b1;
          irq_err  <= 1'b1;
        end else begin
          rx_data   <= dlv_data;
          rx_valid  <= 1'b1;
          err_par   <= dlv_perr;
          err_frame <= dlv_ferr;
          irq_rx    <= 1'b1;
          irq_err   <= dlv_perr || dlv_ferr;
        end
      end
    end
  end

  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_rd) |=> $stable(rx_data)); // R5
  AST_OVR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_over) |-> irq_err); // R5
  AST_WAKE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && cfg_wake && !cfg_sync) |-> rx_data[8]); // R6
  AST_SCLK_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(txd)); // R8
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> !tx_busy); // R11
  AST_RX_STROBE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_valid); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !dlv) |=> (!rx_valid && !err_over && !err_par && !err_frame)); // R13
endmodule

// File: tb/sim_dualmode_serial.sv
module sim_dualmode_serial;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic cfg_sync = 0, cfg_nine = 0, cfg_wake = 0, cfg_two_stop = 0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_loop = 0;
  logic [8:0] tx_data = '0;
  logic tx_wr = 0, sync_rx_go = 0, rx_rd = 0, rxd = 1'b1;
  logic tx_busy, rx_valid, err_par, err_frame, err_over;
  logic irq_tx, irq_rx, irq_err, txd, sclk;
  logic [8:0] rx_data;

  int nchk = 0, nfail = 0;
  int n_itx = 0, n_irx = 0, n_ierr = 0;

  dualmode_serial u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_sync(cfg_sync), .cfg_nine(cfg_nine), .cfg_wake(cfg_wake),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_loop(cfg_loop), .tx_data(tx_data), .tx_wr(tx_wr), .sync_rx_go(sync_rx_go),
    .tx_busy(tx_busy), .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
    .err_par(err_par), .err_frame(err_frame), .err_over(err_over),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .txd(txd), .sclk(sclk), .rxd(rxd)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (irq_tx) n_itx++;
    if (irq_rx) n_irx++;
    if (irq_err) n_ierr++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input bit sy, input bit nine, input bit wake, input bit two,
                         input bit par, input bit odd, input bit loop);
    @(negedge clk);
    cfg_sync = sy; cfg_nine = nine; cfg_wake = wake; cfg_two_stop = two;
    cfg_par_en = par; cfg_par_odd = odd; cfg_loop = loop;
  endtask

  function automatic logic exp_bit(int k, logic [8:0] d, int nd, bit par, bit odd);
    logic [8:0] m;
    m = (nd == 9) ? d : {1'b0, d[7:0]};
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (par && k == nd + 1) return (^m) ^ odd;
    return 1'b1;
  endfunction

  task automatic pulse_wr(input logic [8:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic do_read(input string tag);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    check({tag, " R13 valid cleared"}, rx_valid, 0);
    check({tag, " R13 flags cleared"}, {err_par, err_frame, err_over}, 0);
  endtask

  task automatic t_reset;
    check("R1 txd idle", txd, 1);
    check("R8 sclk idle", sclk, 1);
    check("R11 reset outputs", {tx_busy, rx_valid, err_par, err_frame, err_over}, 0);
  endtask

  // R1 R2 R3 R11 R12
  task automatic t_async_tx(input logic [8:0] d, input bit nine, input bit two,
                            input bit par, input bit odd, input bit probe);
    int nd, len, bad, itx0;
    nd = nine ? 9 : 8;
    len = 1 + nd + (par ? 1 : 0) + (two ? 2 : 1);
    bad = 0;
    set_cfg(0, nine, 0, two, par, odd, 0);
    itx0 = n_itx;
    pulse_wr(d);
    for (int e = 1; e <= 16*len; e++) begin
      @(negedge clk);
      if (tx_wr) begin tx_wr = 1'b0; tx_data = d; end
      if (e % 16 == 8 && txd !== exp_bit(e/16, d, nd, par, odd)) begin
        bad++;
        $display("FAIL R1 bit %0d actual=%0b expected=%0b", e/16, txd, exp_bit(e/16, d, nd, par, odd));
      end
      if (probe && e == 56) begin tx_data = ~d; tx_wr = 1'b1; end
      if (e == 16*len - 1) check("R1 busy through last bit", tx_busy, 1);
    end
    check(probe ? "R12 frame unchanged by write while busy" : "R1 R2 R3 frame bits", bad, 0);
    check("R11 irq_tx on final edge", irq_tx, 1);
    check("R1 busy low after frame", tx_busy, 0);
    @(negedge clk);
    check("R11 single irq_tx", n_itx - itx0, 1);
  endtask

  task automatic drive_frame(input logic [8:0] d, input int nd, input bit par,
                             input bit odd, input bit flip, input bit stopv);
    logic [8:0] m;
    m = (nd == 9) ? d : {1'b0, d[7:0]};
    @(negedge clk);
    rxd = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < nd; i++) begin rxd = d[i]; repeat (16) @(negedge clk); end
    if (par) begin rxd = (^m) ^ odd ^ flip; repeat (16) @(negedge clk); end
    rxd = stopv; repeat (16) @(negedge clk);
    rxd = 1'b1; repeat (32) @(negedge clk);
  endtask

  // R2 R3 R4
  task automatic t_async_rx(input string tag, input logic [8:0] d, input bit nine,
                            input bit par, input bit odd, input bit flip, input bit stopv);
    int nd, irx0, ie0;
    nd = nine ? 9 : 8;
    set_cfg(0, nine, 0, 0, par, odd, 0);
    irx0 = n_irx; ie0 = n_ierr;
    drive_frame(d, nd, par, odd, flip, stopv);
    check({tag, " valid"}, rx_valid, 1);
    check({tag, " data"}, rx_data, nine ? d : {1'b0, d[7:0]});
    check({tag, " parity flag"}, err_par, flip);
    check({tag, " frame flag"}, err_frame, !stopv);
    check({tag, " R11 irq_rx"}, n_irx - irx0, 1);
    check({tag, " R11 irq_err"}, n_ierr - ie0, (flip || !stopv) ? 1 : 0);
    do_read(tag);
  endtask

  task automatic t_overrun;
    int ie0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    drive_frame(9'h05A, 8, 0, 0, 0, 1);
    ie0 = n_ierr;
    drive_frame(9'h0C3, 8, 0, 0, 0, 1);
    check("R5 overrun flag", err_over, 1);
    check("R5 first char kept", rx_data, 9'h05A);
    check("R5 R11 overrun strobe", n_ierr - ie0, 1);
    do_read("R5 overrun");
  endtask

  task automatic t_wake;
    int irx0;
    set_cfg(0, 0, 1, 0, 0, 0, 0);
    irx0 = n_irx;
    drive_frame(9'h077, 9, 0, 0, 0, 1);
    check("R6 data char dropped", rx_valid, 0);
    check("R6 no strobe on dropped", n_irx - irx0, 0);
    drive_frame(9'h112, 9, 0, 0, 0, 1);
    check("R6 address char valid", rx_valid, 1);
    check("R6 address char data", rx_data, 9'h112);
    do_read("R6");
  endtask

  task automatic t_false_start;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rxd = 1'b0;
    repeat (5) @(negedge clk); rxd = 1'b1;
    repeat (300) @(negedge clk);
    check("R7 short pulse no char", rx_valid, 0);
    drive_frame(9'h0A5, 8, 0, 0, 0, 1);
    check("R7 next frame received", rx_data, 9'h0A5);
    do_read("R7");
  endtask

  task automatic t_loop;
    int hi_bad;
    set_cfg(0, 0, 0, 0, 1, 0, 1);
    @(negedge clk); rxd = 1'b0;
    hi_bad = 0;
    pulse_wr(9'h03C);
    for (int e = 1; e <= 16*11 + 40; e++) begin
      @(negedge clk);
      if (txd !== 1'b1) hi_bad++;
    end
    check("R10 txd held high", hi_bad, 0);
    check("R10 loopback valid", rx_valid, 1);
    check("R10 loopback data", rx_data, 9'h03C);
    check("R10 loopback no error", {err_par, err_frame}, 0);
    rxd = 1'b1;
    do_read("R10");
    set_cfg(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sync_tx(input logic [7:0] d);
    logic [7:0] got;
    int rises, itx0;
    logic prev;
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    itx0 = n_itx; rises = 0; got = '0;
    pulse_wr({1'b1, d});
    prev = sclk;
    check("R8 sclk low in first half", sclk, 0);
    for (int e = 0; e < 150; e++) begin
      @(negedge clk);
      if (sclk && !prev) begin
        if (rises < 8) got[rises] = txd;
        rises++;
      end
      prev = sclk;
    end
    check("R8 sync bits LSB first", got, d);
    check("R8 eight clock edges", rises, 8);
    check("R8 sclk idle after", sclk, 1);
    check("R11 sync irq_tx", n_itx - itx0, 1);
  endtask

  task automatic t_sync_rx(input logic [7:0] d);
    int i, irx0;
    bit drv;
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    irx0 = n_irx; i = 0; drv = 0;
    @(negedge clk); sync_rx_go = 1'b1;
    @(posedge clk);
    @(negedge clk); sync_rx_go = 1'b0;
    for (int e = 0; e < 150; e++) begin
      if (!sclk && !drv && i < 8) begin rxd = d[i]; i++; drv = 1; end
      if (sclk) drv = 0;
      if (e == 20) begin sync_rx_go = 1'b1; tx_data = 9'h0FF; tx_wr = 1'b1; end
      if (e == 21) begin sync_rx_go = 1'b0; tx_wr = 1'b0; end
      @(negedge clk);
    end
    rxd = 1'b1;
    check("R9 sync rx valid", rx_valid, 1);
    check("R9 R12 sync rx data", rx_data, {1'b0, d});
    check("R11 sync irq_rx", n_irx - irx0, 1);
    check("R12 no restart after", tx_busy, 0);
    do_read("R9");
    set_cfg(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_async_tx(9'h0B6, 0, 0, 0, 0, 0);
    t_async_tx(9'h15A, 1, 1, 1, 1, 0);
    t_async_tx(9'h071, 0, 0, 1, 0, 1);
    t_async_rx("R2 eight bit", 9'h0E4, 0, 0, 0, 0, 1);
    t_async_rx("R2 R3 nine bit odd", 9'h1A3, 1, 1, 1, 0, 1);
    t_async_rx("R3 parity mismatch", 9'h0F0, 0, 1, 0, 1, 1);
    t_async_rx("R4 stop low", 9'h033, 0, 0, 0, 0, 0);
    t_overrun();
    t_wake();
    t_false_start();
    t_loop();
    t_sync_tx(8'h9D);
    t_sync_rx(8'h6B);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule